// File: doc/BRIEF.md
# SPI Controller with Control Register

This block is a serial peripheral interface port for a small microcontroller. Software reaches it through a byte-wide register port with two locations: a control/status register and a data register. In master mode the block generates the serial clock from the core clock and starts a frame whenever software writes the data register while the port is idle. In slave mode it follows an external serial clock whenever the active-low select input is asserted.

Every frame is eight bits long and is shifted most significant bit first. Clock polarity, clock phase and a two-bit master rate code can all be selected. At the end of each frame the block sets a completion flag and drives its interrupt request. If software writes the data register during a frame, the block refuses the write and sets a collision flag instead.

The register port has no wait states. The read data is combinational from the address, and strobes are sampled on the rising edge of the core clock. Register address 0 selects the control register and address 1 selects the data register.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x05. Its bits, from bit 7 down to bit 0, are: completion flag, collision flag, enable, master select, clock polarity, clock phase, and a two-bit rate code in bits 1:0.
- R2: In master mode, a data write while idle starts an 8-bit frame. The frame is sent MSB first on mosi_o. The byte captured from miso_i can be read back from the data register after the frame.
- R3: In master mode, rate codes 0, 1, 2 and 3 give a serial clock period of 2, 4, 8 and 16 core clock cycles.
- R4: When no frame is running, sclk_o sits at the level of the polarity bit: high when the bit is 1 and low when it is 0.
- R5: With the phase bit at 1, data changes on the leading clock edge and is sampled on the trailing edge. With the phase bit at 0, the first bit is presented before the first edge, data is sampled on the leading edge, and data changes on the trailing edge.
- R6: The completion flag is set at the end of every frame. It is cleared by a read of the data register or by writing 0 to bit 7 of the control register. Writing 1 to bit 7 leaves the flag unchanged.
- R7: A data write during a frame sets the collision flag and changes neither the frame in flight nor its data. The flag is cleared only by writing 0 to bit 6 of the control register; a data read leaves it set.
- R8: irq is high exactly while the enable bit and the completion flag are both 1.
- R9: With the enable bit at 0, all three pin output enables are low, and a data write starts no frame.
- R10: In slave mode sclk_oe is low, and miso_oe is high only while ss_n_i is low. Bits are shifted only while ss_n_i is low. Raising ss_n_i in the middle of a frame discards the partial frame, so the next select begins a fresh 8-bit frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a data read clears the completion flag) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed register |
| irq | output | 1 | Interrupt request |
| sclk_i | input | 1 | Serial clock in (slave mode) |
| sclk_o | output | 1 | Serial clock out (master mode) |
| sclk_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Serial data in (slave mode) |
| mosi_o | output | 1 | Serial data out (master mode) |
| mosi_oe | output | 1 | mosi_o output enable |
| miso_i | input | 1 | Serial data in (master mode) |
| miso_o | output | 1 | Serial data out (slave mode) |
| miso_oe | output | 1 | miso_o output enable |
| ss_n_i | input | 1 | Slave select, active low |

## Verification
The hardest case to reach from the pins is a slave frame cut off part way through. The partial bits have already moved the shift register, so the port must come out of it with a cleared bit count and no false collision. To get there, the bench selects the slave, clocks three bits, releases select and reloads the data register. It then runs a full frame and checks both bytes exchanged. A second hard case is a data write that lands during a slow master frame. The bench places this write several cycles after the start and checks that the bytes seen on both pins match the original transfer.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef struct packed {
    logic       done;    // bit 7
    logic       coll;    // bit 6
    logic       en;      // bit 5
    logic       master;  // bit 4
    logic       cpol;    // bit 3
    logic       cpha;    // bit 2
    logic [1:0] rate;    // bits 1:0
  } ctrl_t;

  localparam logic [7:0] CTRL_RST  = 8'h05;
  localparam logic       ADDR_CTRL = 1'b0;
  localparam logic       ADDR_DATA = 1'b1;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= stg_q[s-1];
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  assign limit = CNT_W'((32'd1 << rate) - 32'd1);
  assign tick  = run && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick || (limit == '0)); // R3
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               lead,
  input  logic               trail,
  input  logic               cpha,
  input  logic               sin,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_val,
  output logic [FRAME_W-1:0] sr_o,
  output logic               act_o,
  output logic               frame_end
);
  localparam int              BC_W = $clog2(FRAME_W);
  localparam logic [BC_W-1:0] LAST = BC_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [BC_W-1:0]    cnt_q, cnt_d;
  logic               cap_q, cap_d, act_q, act_d;

  assign frame_end = trail && !clear && !load && (cnt_q == LAST);

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    cap_d = cap_q;
    act_d = act_q;
    if (load) begin
      sr_d  = load_val;
      cnt_d = '0;
      act_d = 1'b0;
    end else if (clear) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else begin
      if (lead) begin
        act_d = 1'b1;
        if (!cpha)              cap_d = sin;
        else if (cnt_q != '0)   sr_d  = {sr_q[FRAME_W-2:0], cap_q};
      end
      if (trail) begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == LAST) act_d = 1'b0;
        if (!cpha) begin
          sr_d = {sr_q[FRAME_W-2:0], cap_q};
        end else begin
          cap_d = sin;
          if (cnt_q == LAST) sr_d = {sr_q[FRAME_W-2:0], sin};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      cap_q <= 1'b0;
      act_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      cap_q <= cap_d;
      act_q <= act_d;
    end

  assign sr_o  = sr_q;
  assign act_o = act_q;

  AST_END_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (cnt_q == '0) && !act_q); // R2
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !load) |=> (cnt_q == '0) && !act_q); // R10
endmodule

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       rd,
  input  logic       addr,
  input  logic [7:0] wdata,
  input  logic       busy,
  input  logic       frame_end,
  output ctrl_t      ctrl_o
);
  ctrl_t ctrl_q, ctrl_d, wv;

  assign wv = ctrl_t'(wdata);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr && addr == ADDR_CTRL) begin
      ctrl_d.en     = wv.en;
      ctrl_d.master = wv.master;
      ctrl_d.cpol   = wv.cpol;
      ctrl_d.cpha   = wv.cpha;
      ctrl_d.rate   = wv.rate;
      if (!wv.done) ctrl_d.done = 1'b0;
      if (!wv.coll) ctrl_d.coll = 1'b0;
    end
    if (rd && addr == ADDR_DATA)          ctrl_d.done = 1'b0;
    if (wr && addr == ADDR_DATA && busy)  ctrl_d.coll = 1'b1;
    if (frame_end)                        ctrl_d.done = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_q <= ctrl_t'(CTRL_RST);
    else        ctrl_q <= ctrl_d;

  assign ctrl_o = ctrl_q;

  AST_COLL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_DATA && busy) |=> ctrl_q.coll); // R7
  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.coll && !(wr && addr == ADDR_CTRL && !wdata[6])) |=> ctrl_q.coll); // R7
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> ctrl_q.done); // R6
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n_i
);
  localparam int RATE_W = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  assign rst_q = rst_pipe[1];

  // pin synchronisers: {ss_n, mosi, sclk}
  logic [2:0] pins_s;
  logic       ss_s, mosi_s, sclk_s;
  spi_port_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_q), .d({ss_n_i, mosi_i, sclk_i}), .q(pins_s));
  assign {ss_s, mosi_s, sclk_s} = pins_s;

  ctrl_t             ctrl;
  logic              master_mode, slave_mode, ss_act, busy;
  logic              run_q, run_d, phase_q, phase_d, sclk_prev_q;
  logic              tick, m_lead, m_trail, s_lvl, s_prev, s_lead, s_trail;
  logic              lead, trail, load, clear, sin, frame_end, sh_act;
  logic [DATA_W-1:0] sr;

  assign master_mode = ctrl.en && ctrl.master;
  assign slave_mode  = ctrl.en && !ctrl.master;
  assign ss_act      = slave_mode && !ss_s;
  assign busy        = master_mode ? run_q : sh_act;
  assign load        = reg_wr && (reg_addr == ADDR_DATA) && !busy;

  spi_port_regs u_regs (
    .clk(clk), .rst_n(rst_q), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata[7:0]), .busy(busy), .frame_end(frame_end), .ctrl_o(ctrl));

  spi_port_clkgen #(.RATE_W(RATE_W)) u_clkgen (
    .clk(clk), .rst_n(rst_q), .run(run_q), .rate(ctrl.rate), .tick(tick));

  // master edge generation
  assign m_lead  = tick && !phase_q;
  assign m_trail = tick &&  phase_q;

  // slave edge detection, relative to the idle level
  assign s_lvl   = sclk_s ^ ctrl.cpol;
  assign s_prev  = sclk_prev_q ^ ctrl.cpol;
  assign s_lead  = ss_act &&  s_lvl && !s_prev;
  assign s_trail = ss_act && !s_lvl &&  s_prev;

  assign lead  = master_mode ? m_lead  : s_lead;
  assign trail = master_mode ? m_trail : s_trail;
  assign clear = !ctrl.en || (slave_mode && ss_s);
  assign sin   = master_mode ? miso_i : mosi_s;

  always_comb begin
    run_d   = run_q;
    phase_d = phase_q;
    if (!master_mode)   run_d = 1'b0;
    else if (load)      run_d = 1'b1;
    else if (frame_end) run_d = 1'b0;
    if (!run_q)         phase_d = 1'b0;
    else if (tick)      phase_d = !phase_q;
  end

  always_ff @(posedge clk or negedge rst_q)
    if (!rst_q) begin
      run_q       <= 1'b0;
      phase_q     <= 1'b0;
      sclk_prev_q <= 1'b0;
    end else begin
      run_q       <= run_d;
      phase_q     <= phase_d;
      sclk_prev_q <= sclk_s;
    end

  spi_port_shifter #(.FRAME_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_q), .clear(clear), .lead(lead), .trail(trail),
    .cpha(ctrl.cpha), .sin(sin), .load(load), .load_val(reg_wdata),
    .sr_o(sr), .act_o(sh_act), .frame_end(frame_end));

  assign sclk_o    = ctrl.cpol ^ phase_q;
  assign sclk_oe   = master_mode;
  assign mosi_o    = sr[DATA_W-1];
  assign mosi_oe   = master_mode;
  assign miso_o    = sr[DATA_W-1];
  assign miso_oe   = ss_act;
  assign irq       = ctrl.en && ctrl.done;
  assign reg_rdata = (reg_addr == ADDR_CTRL) ? DATA_W'(ctrl) : sr;

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_q)
    (master_mode && !run_q) |-> (sclk_o == ctrl.cpol)); // R4
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    !ctrl.en |-> !(sclk_oe || mosi_oe || miso_oe)); // R9
  AST_OFF_NO_RUN: assert property (@(posedge clk) disable iff (!rst_q)
    !ctrl.en |=> !run_q); // R9
  AST_SLAVE_DESEL_OE: assert property (@(posedge clk) disable iff (!rst_q)
    (slave_mode && ss_s) |-> !miso_oe && !sclk_oe); // R10
endmodule

// File: tb/sim_spi_port.sv
module sim_spi_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic       sclk_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;

  int checks = 0, failures = 0;
  bit ended = 0, mon_on = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  spi_port u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_i(mosi_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o),
    .miso_oe(miso_oe), .ss_n_i(ss_n_i));

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // scoreboard monitor: pops one expected byte per completed frame
  initial begin
    logic [7:0] c, d;
    forever begin
      @(negedge clk);
      if (mon_on && irq) begin
        rd_reg(1'b0, c);
        chk("R6 completion flag set after frame", 32'(c[7]), 1);
        rd_reg(1'b1, d);
        if (exp_q.size() == 0) chk("R2 unexpected frame", 32'(d), 32'hFFFF);
        else begin
          chk("R2 received byte", 32'(d), 32'(exp_q[0]));
          rd_reg(1'b0, c);
          chk("R6 data read clears completion flag", 32'(c[7]), 0);
          chk("R8 irq low after flag cleared", 32'(irq), 0);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  // bench-side slave of a master-mode frame
  task automatic master_xfer(logic cpol, logic cpha, logic [1:0] rate,
                             logic [7:0] tx, logic [7:0] stx, bit collide);
    logic [7:0] got = '0;
    logic [7:0] c;
    int period = 0;
    wr_reg(1'b0, {2'b11, 1'b1, 1'b1, cpol, cpha, rate});
    @(negedge clk);
    chk("R4 sclk idle level", 32'(sclk_o), 32'(cpol));
    chk("R2 master output enables", 32'({sclk_oe, mosi_oe, miso_oe}), 32'b110);
    miso_i = stx[7];
    exp_q.push_back(stx);
    fork
      begin
        int cyc = 0, t0 = 0, leads = 0, trails = 0;
        logic prev = cpol, last_mosi = 1'b0;
        while (trails < 8) begin
          @(negedge clk); cyc++;
          if (sclk_o != prev) begin
            if (sclk_o != cpol) begin
              if (leads == 0) t0 = cyc;
              if (leads == 1) period = cyc - t0;
              if (!cpha) got[7-leads] = mosi_o;
              else       miso_i = stx[7-leads];
              last_mosi = mosi_o;
              leads++;
            end else begin
              if (cpha)            got[7-trails] = last_mosi;
              else if (trails < 7) miso_i = stx[6-trails];
              trails++;
            end
            prev = sclk_o;
          end else last_mosi = mosi_o;
        end
      end
      begin
        wr_reg(1'b1, tx);
        if (collide) begin
          repeat (6) @(negedge clk);
          wr_reg(1'b1, ~tx);
        end
      end
    join
    chk("R2 R5 byte seen on mosi", 32'(got), 32'(tx));
    chk("R3 serial clock period", period, 2 << rate);
    @(negedge clk);
    chk("R4 sclk back at idle level", 32'(sclk_o), 32'(cpol));
    if (mon_on) drain();
    if (collide) begin
      rd_reg(1'b0, c);
      chk("R7 collision flag survives data read", 32'(c[6]), 1);
      wr_reg(1'b0, {2'b10, 1'b1, 1'b1, cpol, cpha, rate});
      rd_reg(1'b0, c);
      chk("R7 collision flag cleared by writing 0", 32'(c[6]), 0);
    end
  endtask

  // one slave-mode bit driven by the bench as master
  task automatic bit_clock(logic cpol, logic cpha, logic b, output logic s);
    if (!cpha) begin
      mosi_i = b;
      repeat (8) @(negedge clk);
      s = miso_o;
      sclk_i = !cpol;
      repeat (8) @(negedge clk);
      sclk_i = cpol;
    end else begin
      sclk_i = !cpol;
      mosi_i = b;
      repeat (8) @(negedge clk);
      s = miso_o;
      sclk_i = cpol;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic slave_xfer(logic cpol, logic cpha, logic [7:0] btx,
                            logic [7:0] dtx, int abort_bits);
    logic [7:0] got = '0;
    logic [7:0] c;
    logic dummy;
    sclk_i = cpol; ss_n_i = 1'b1;
    wr_reg(1'b0, {2'b11, 1'b1, 1'b0, cpol, cpha, 2'b00});
    wr_reg(1'b1, dtx);
    repeat (8) @(negedge clk);
    chk("R10 deselected: no pin driven", 32'({sclk_oe, mosi_oe, miso_oe}), 0);
    if (abort_bits > 0) begin
      ss_n_i = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < abort_bits; i++) bit_clock(cpol, cpha, 1'b1, dummy);
      ss_n_i = 1'b1;
      repeat (8) @(negedge clk);
      wr_reg(1'b1, dtx);
      rd_reg(1'b0, c);
      chk("R10 aborted frame leaves no collision or completion", 32'(c[7:6]), 0);
    end
    exp_q.push_back(btx);
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 selected: miso driven, sclk not", 32'({sclk_oe, miso_oe}), 32'b01);
    for (int i = 0; i < 8; i++) bit_clock(cpol, cpha, btx[7-i], got[7-i]);
    ss_n_i = 1'b1;
    repeat (8) @(negedge clk);
    chk("R10 R5 byte seen on miso", 32'(got), 32'(dtx));
    drain();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] c, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    rd_reg(1'b0, c);
    chk("R1 control reset value", 32'(c), 32'h05);
    chk("R1 R8 irq low after reset", 32'(irq), 0);
    chk("R9 no pin driven after reset", 32'({sclk_oe, mosi_oe, miso_oe}), 0);

    // R9: disabled master does not start on a data write
    wr_reg(1'b0, 8'b1101_0000);
    wr_reg(1'b1, 8'h3C);
    repeat (40) @(negedge clk);
    chk("R9 disabled: no pin driven", 32'({sclk_oe, mosi_oe, miso_oe}), 0);
    rd_reg(1'b0, c);
    chk("R9 disabled: no frame completes", 32'(c[7]), 0);

    mon_on = 1;
    master_xfer(1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C, 0);
    master_xfer(1'b1, 1'b1, 2'd1, 8'h81, 8'h7E, 0);
    master_xfer(1'b0, 1'b1, 2'd2, 8'h5A, 8'hC3, 0);
    master_xfer(1'b1, 1'b0, 2'd3, 8'h0F, 8'hF0, 0);
    master_xfer(1'b0, 1'b0, 2'd3, 8'h96, 8'h69, 1);

    // flag handling with the monitor paused
    mon_on = 0;
    master_xfer(1'b1, 1'b1, 2'd0, 8'h12, 8'hE4, 0);
    @(negedge clk);
    chk("R8 irq high with flag and enable", 32'(irq), 1);
    wr_reg(1'b0, {2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0});
    chk("R8 irq low when disabled", 32'(irq), 0);
    wr_reg(1'b0, {2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0});
    rd_reg(1'b0, c);
    chk("R6 writing 1 keeps completion flag", 32'(c[7]), 1);
    chk("R8 irq back high when re-enabled", 32'(irq), 1);
    wr_reg(1'b0, {2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0});
    rd_reg(1'b0, c);
    chk("R6 writing 0 clears completion flag", 32'(c[7]), 0);
    chk("R8 irq low after software clear", 32'(irq), 0);
    rd_reg(1'b1, d);
    chk("R2 received byte after flag clear", 32'(d), 32'(exp_q[0]));
    void'(exp_q.pop_front());
    mon_on = 1;

    slave_xfer(1'b0, 1'b0, 8'hC6, 8'h39, 0);
    slave_xfer(1'b1, 1'b1, 8'h4B, 8'hB4, 0);
    slave_xfer(1'b0, 1'b1, 8'hE1, 8'h1E, 3);
    slave_xfer(1'b1, 1'b0, 8'h77, 8'h88, 3);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule